// File: doc/BRIEF.md
# UART DMA Request Generator

This block produces the two active-low DMA request lines of a FIFO-equipped UART: one asking a DMA controller to drain received characters and one asking it to refill the transmitter. It watches the occupancy of the receive and transmit paths, the receive trigger-level and character-timeout flags, the FIFO-enable control bit and the DMA mode control bit. From these it decides whether a request is pending. The FIFOs themselves, the trigger comparison and the timeout counter live elsewhere and reach this block only as inputs.

Two handshake styles are offered. In single-transfer style the request simply follows occupancy. The receive request is low while any character waits. The transmit request is low while the transmitter holds nothing. In multi-transfer style both requests have hysteresis. The receive request starts at the trigger level or on a timeout, and it holds until the receive side is empty. The transmit request starts when the transmitter is empty, and it holds until the transmit FIFO is full. With the FIFOs disabled the block runs in character mode. There it looks at a holding-register flag instead of a count, and it always uses single-transfer style.

Top module: `uart_dma_ready`

## Requirements
- R1: While `rst` is high, both `rx_req_n` and `tx_req_n` are driven high on every clock edge.
- R2: Multi-transfer style is in force only when `fifo_en` = 1 and `dma_sel` = 1. When `fifo_en` = 0, `dma_sel` has no effect. Occupancy then comes from `rx_hold_full` and `tx_hold_empty`, and the counts are ignored.
- R3: In single-transfer style, `rx_req_n` is low in the clock after a character is present and high in the clock after none is present. A character is present when `rx_count` > 0 in FIFO mode, or when `rx_hold_full` = 1 in character mode.
- R4: In multi-transfer style, an inactive `rx_req_n` goes low in the clock after `rx_trig_hit` or `rx_timeout` is seen with `rx_count` > 0. Data present without either flag leaves it high.
- R5: In multi-transfer style, an active `rx_req_n` stays low while `rx_count` > 0, even with both flags low. It goes high in the clock after `rx_count` reaches 0.
- R6: In single-transfer style, `tx_req_n` is low in the clock after the transmitter is empty and high in the clock after it is not. Empty means `tx_count` = 0 in FIFO mode, or `tx_hold_empty` = 1 in character mode.
- R7: In multi-transfer style, `tx_req_n` goes low in the clock after `tx_count` = 0. It stays low while `tx_count` < FIFO_DEPTH, and goes high in the clock after `tx_count` reaches FIFO_DEPTH. It then stays high until `tx_count` is 0 again.
- R8: A change of the effective style applies from the next clock edge. On that edge any held request is dropped, so entering multi-transfer style asserts a request only on its own start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| fifo_en | input | 1 | FIFO mode enable control bit |
| dma_sel | input | 1 | DMA style select (1 = multi-transfer) |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_hold_full | input | 1 | Receive holding register full (character mode) |
| rx_trig_hit | input | 1 | Receive trigger level reached |
| rx_timeout | input | 1 | Receive character timeout |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_hold_empty | input | 1 | Transmit holding register empty (character mode) |
| rx_req_n | output | 1 | Receive DMA request, active low |
| tx_req_n | output | 1 | Transmit DMA request, active low |

## Verification
The embedded assertions check the following on every cycle:
- reset drives both requests high;
- single-transfer requests follow occupancy;
- a held receive request survives while data remains and drops once empty;
- a receive request never starts in multi-transfer style without a trigger or timeout;
- the transmit request is released at full and stays released until empty.

Other behaviour can only be shown by the directed scenarios:
- character mode ignoring the counts and the style bit;
- a full transmit fill and drain sequence;
- the loss of a held request when the style is toggled away and back.

// File: rtl/uart_dma_ready.sv
module uart_dma_ready #(
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             dma_sel,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_hold_full,
  input  logic             rx_trig_hit,
  input  logic             rx_timeout,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             tx_hold_empty,
  output logic             rx_req_n,
  output logic             tx_req_n
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

  logic multi, multi_q, style_chg;
  logic rx_have, tx_empty, tx_full, rx_start;
  logic rx_act, tx_act;

  assign multi     = fifo_en & dma_sel;
  assign style_chg = multi ^ multi_q;
  assign rx_have   = fifo_en ? (rx_count != '0) : rx_hold_full;
  assign tx_empty  = fifo_en ? (tx_count == '0) : tx_hold_empty;
  assign tx_full   = fifo_en & (tx_count >= FULL_CNT);
  assign rx_start  = rx_trig_hit | rx_timeout;

  always_ff @(posedge clk) begin
    if (rst) begin
      multi_q <= 1'b0;
      rx_act  <= 1'b0;
      tx_act  <= 1'b0;
    end else begin
      multi_q <= multi;
      if (!multi) begin
        rx_act <= rx_have;
        tx_act <= tx_empty;
      end else if (style_chg) begin
        rx_act <= rx_have & rx_start;
        tx_act <= tx_empty;
      end else begin
        rx_act <= rx_have & (rx_act | rx_start);
        tx_act <= !tx_full & (tx_act | tx_empty);
      end
    end
  end

  assign rx_req_n = ~rx_act;
  assign tx_req_n = ~tx_act;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (rx_req_n && tx_req_n));

  assert_single_rx_follow_R3: assert property (@(posedge clk) disable iff (rst)
    !multi |=> (rx_req_n == !$past(rx_have)));

  assert_multi_rx_needs_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (multi && rx_req_n && !rx_start) |=> rx_req_n);

  assert_multi_rx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (multi && !style_chg && !rx_req_n && rx_have) |=> !rx_req_n);

  assert_multi_rx_release_R5: assert property (@(posedge clk) disable iff (rst)
    (multi && !rx_have) |=> rx_req_n);

  assert_single_tx_follow_R6: assert property (@(posedge clk) disable iff (rst)
    (!multi && !tx_empty) |=> tx_req_n);

  assert_multi_tx_full_R7: assert property (@(posedge clk) disable iff (rst)
    (multi && tx_full) |=> tx_req_n);

  assert_multi_tx_stay_off_R7: assert property (@(posedge clk) disable iff (rst)
    (multi && !style_chg && tx_req_n && !tx_empty) |=> tx_req_n);

endmodule

// File: tb/test_uart_dma_ready.sv
module test_uart_dma_ready;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_en = 1'b0, dma_sel = 1'b0;
  logic [CW-1:0] rx_count = '0, tx_count = '0;
  logic rx_hold_full = 1'b0, rx_trig_hit = 1'b0, rx_timeout = 1'b0, tx_hold_empty = 1'b0;
  logic rx_req_n, tx_req_n;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  uart_dma_ready #(.FIFO_DEPTH(DEPTH)) i_uart_dma_ready (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_sel(dma_sel),
    .rx_count(rx_count), .rx_hold_full(rx_hold_full), .rx_trig_hit(rx_trig_hit),
    .rx_timeout(rx_timeout), .tx_count(tx_count), .tx_hold_empty(tx_hold_empty),
    .rx_req_n(rx_req_n), .tx_req_n(tx_req_n));

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  task automatic step(input logic fe, input logic ds, input int rxc, input logic hf,
                      input logic trg, input logic tmo, input int txc, input logic he);
    @(negedge clk);
    fifo_en = fe; dma_sel = ds; rx_count = CW'(rxc); rx_hold_full = hf;
    rx_trig_hit = trg; rx_timeout = tmo; tx_count = CW'(txc); tx_hold_empty = he;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset();
    step(1, 1, 3, 1, 1, 0, 0, 1);
    chk("R1 rx", rx_req_n, 1'b1);
    chk("R1 tx", tx_req_n, 1'b1);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_char_mode();
    step(0, 1, 0, 1, 0, 0, 5, 1);
    chk("R2 R3 rx hold full", rx_req_n, 1'b0);
    chk("R2 R6 tx hold empty", tx_req_n, 1'b0);
    step(0, 1, 5, 0, 1, 0, 0, 0);
    chk("R2 R3 rx count ignored", rx_req_n, 1'b1);
    chk("R2 R6 tx count ignored", tx_req_n, 1'b1);
  endtask

  task automatic t_fifo_single();
    step(1, 0, 1, 0, 0, 0, 0, 0);
    chk("R3 rx one char", rx_req_n, 1'b0);
    chk("R6 tx empty", tx_req_n, 1'b0);
    step(1, 0, 0, 1, 0, 0, 3, 1);
    chk("R3 rx none", rx_req_n, 1'b1);
    chk("R6 tx busy", tx_req_n, 1'b1);
  endtask

  task automatic t_multi_rx();
    step(1, 1, 0, 0, 0, 0, 8, 0);
    step(1, 1, 3, 0, 0, 0, 8, 0);
    chk("R4 rx no cause", rx_req_n, 1'b1);
    step(1, 1, 4, 0, 1, 0, 8, 0);
    chk("R4 rx trigger", rx_req_n, 1'b0);
    step(1, 1, 2, 0, 0, 0, 8, 0);
    chk("R5 rx held", rx_req_n, 1'b0);
    step(1, 1, 0, 0, 0, 0, 8, 0);
    chk("R5 rx drained", rx_req_n, 1'b1);
    step(1, 1, 1, 0, 0, 1, 8, 0);
    chk("R4 rx timeout", rx_req_n, 1'b0);
    step(1, 1, 0, 0, 0, 0, 8, 0);
    chk("R5 rx drained again", rx_req_n, 1'b1);
  endtask

  task automatic t_multi_tx();
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 tx empty", tx_req_n, 1'b0);
    step(1, 1, 0, 0, 0, 0, 8, 0);
    chk("R7 tx partial held", tx_req_n, 1'b0);
    step(1, 1, 0, 0, 0, 0, DEPTH - 1, 0);
    chk("R7 tx one short", tx_req_n, 1'b0);
    step(1, 1, 0, 0, 0, 0, DEPTH, 0);
    chk("R7 tx full", tx_req_n, 1'b1);
    step(1, 1, 0, 0, 0, 0, 8, 0);
    chk("R7 tx stays off", tx_req_n, 1'b1);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R7 tx empty again", tx_req_n, 1'b0);
  endtask

  task automatic t_style_change();
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 4, 0, 1, 0, 8, 0);
    chk("R8 setup rx", rx_req_n, 1'b0);
    chk("R8 setup tx", tx_req_n, 1'b0);
    step(1, 0, 4, 0, 0, 0, 8, 0);
    chk("R8 single rx", rx_req_n, 1'b0);
    chk("R8 single tx", tx_req_n, 1'b1);
    step(1, 1, 4, 0, 0, 0, 8, 0);
    chk("R8 rx cleared", rx_req_n, 1'b1);
    chk("R8 tx cleared", tx_req_n, 1'b1);
    step(1, 1, 4, 0, 0, 0, 0, 0);
    chk("R8 tx restart", tx_req_n, 1'b0);
    step(0, 1, 4, 0, 0, 0, 0, 0);
    chk("R2 R8 char forces single", rx_req_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_char_mode();
    t_fifo_single();
    t_multi_rx();
    t_multi_tx();
    t_style_change();
    summary();
  end
endmodule